// File: doc/BRIEF.md
# Two-Level Lookahead Adder

A purely combinational 16-bit adder that does not ripple. The operands are split into four 4-bit slices. Each slice forms its own per-bit generate (AND) and propagate (OR) terms. From these and the slice's incoming carry, it computes every internal carry as a flat sum of products. Each slice also reports two summary terms. The group generate says the slice produces a carry out by itself. The group propagate says every bit position of the slice would pass a carry along.

A second lookahead stage takes the four pairs of group terms and the external carry-in. It produces the carries entering bits 4, 8 and 12 and the final carry out of bit 15. Each of these is one flat sum of products. None is chained from the stage below it. The group terms also leave the block on their own ports, so a debug probe can see which slices generate and which pass a carry.

Top module: `gcla_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, for every operand pair and for both values of the carry-in.
- R2: `cout_o` equals bit 16 of the 17-bit result `a_i + b_i + cin_i`.
- R3: Bit k of `grp_gen_o` covers operand bits 4k+3 down to 4k. It is 1 exactly when that slice's two 4-bit operand fields sum to more than 15, which is the slice's carry-out with a carry-in of 0.
- R4: Bit k of `grp_prop_o` covers operand bits 4k+3 down to 4k. It is 1 exactly when every bit position in that slice has `a_i` OR `b_i` set.
- R5: For each slice, `grp_gen_o[k] | grp_prop_o[k]` equals the slice's carry-out with a carry-in of 1.
- R6: The carry-in is a live input. When the operands set every propagate term but no generate term (for example 0xAAAA + 0x5555), a carry-in of 0 gives sum 0xFFFF with carry-out 0. A carry-in of 1 gives sum 0x0000 with carry-out 1.
- R7: A carry generated in the lowest slice and propagated through all three upper slices reaches `cout_o` in the same evaluation. For example, 0xFFFF + 0x0001 with carry-in 0 gives sum 0x0000 and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 4 | Group generate, one bit per 4-bit slice |
| grp_prop_o | output | 4 | Group propagate, one bit per 4-bit slice |

## Verification
A single slice can assert its group generate and its group propagate at once. For example, 0xF + 0xF sets both. The carry into that slice must then not matter to its carry out, while its sum bits still depend on it. Directed vectors set both terms in chosen slices, with the carry-in at 0 and then at 1. The bench judges the sum, the carry-out and both group ports against a behavioural 17-bit addition and per-slice arithmetic. Random vectors then mix slices that generate, propagate, do both, or do neither.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
    localparam int unsigned GROUP_W  = 4;
    localparam int unsigned N_GROUPS = 4;
    localparam int unsigned ADD_W    = GROUP_W * N_GROUPS;

    typedef struct packed {
        logic gen;
        logic prop;
    } grp_term_t;
endpackage

// File: rtl/gcla_group.sv
module gcla_group #(
    parameter int unsigned GW = gcla_pkg::GROUP_W
) (
    input  logic [GW-1:0]         a_i,
    input  logic [GW-1:0]         b_i,
    input  logic                  cin_i,
    output logic [GW-1:0]         sum_o,
    output gcla_pkg::grp_term_t   term_o
);
    logic [GW-1:0] bit_gen;
    logic [GW-1:0] bit_prop;
    logic [GW-1:0] carry_d;

    assign bit_gen  = a_i & b_i;
    assign bit_prop = a_i | b_i;

    // carry into bit i: OR over j<i of gen[j]·prop[j+1..i-1], plus prop[0..i-1]·cin
    always_comb begin
        for (int i = 0; i < int'(GW); i++) begin
            logic acc;
            logic chain;
            acc   = 1'b0;
            chain = cin_i;
            for (int j = 0; j < i; j++) begin
                logic term;
                term = bit_gen[j];
                for (int k = j + 1; k < i; k++) begin
                    term = term & bit_prop[k];
                end
                acc   = acc | term;
                chain = chain & bit_prop[j];
            end
            carry_d[i] = acc | chain;
        end
    end

    assign sum_o = a_i ^ b_i ^ carry_d;

    always_comb begin
        logic gacc;
        logic pacc;
        gacc = 1'b0;
        pacc = 1'b1;
        for (int j = 0; j < int'(GW); j++) begin
            logic term;
            term = bit_gen[j];
            for (int k = j + 1; k < int'(GW); k++) begin
                term = term & bit_prop[k];
            end
            gacc = gacc | term;
            pacc = pacc & bit_prop[j];
        end
        term_o.gen  = gacc;
        term_o.prop = pacc;
    end
endmodule

// File: rtl/gcla_lookahead.sv
module gcla_lookahead #(
    parameter int unsigned NG = gcla_pkg::N_GROUPS
) (
    input  logic [NG-1:0] gg_i,
    input  logic [NG-1:0] gp_i,
    input  logic          cin_i,
    output logic [NG:0]   carry_o
);
    // carry into group k, flat: no use of carry_o[k-1]
    always_comb begin
        for (int k = 0; k <= int'(NG); k++) begin
            logic acc;
            logic chain;
            acc   = 1'b0;
            chain = cin_i;
            for (int j = 0; j < k; j++) begin
                logic term;
                term = gg_i[j];
                for (int m = j + 1; m < k; m++) begin
                    term = term & gp_i[m];
                end
                acc   = acc | term;
                chain = chain & gp_i[j];
            end
            carry_o[k] = acc | chain;
        end
    end
endmodule

// File: rtl/gcla_adder.sv
module gcla_adder #(
    parameter int unsigned GROUP_W  = gcla_pkg::GROUP_W,
    parameter int unsigned N_GROUPS = gcla_pkg::N_GROUPS,
    localparam int unsigned WIDTH   = GROUP_W * N_GROUPS
) (
    input  logic [WIDTH-1:0]    a_i,
    input  logic [WIDTH-1:0]    b_i,
    input  logic                cin_i,
    output logic [WIDTH-1:0]    sum_o,
    output logic                cout_o,
    output logic [N_GROUPS-1:0] grp_gen_o,
    output logic [N_GROUPS-1:0] grp_prop_o
);
    logic [N_GROUPS:0]   grp_carry;
    gcla_pkg::grp_term_t grp_term [N_GROUPS];

    for (genvar g = 0; g < int'(N_GROUPS); g++) begin : g_slice
        gcla_group #(.GW(GROUP_W)) u_group (
            .a_i    (a_i[g*GROUP_W +: GROUP_W]),
            .b_i    (b_i[g*GROUP_W +: GROUP_W]),
            .cin_i  (grp_carry[g]),
            .sum_o  (sum_o[g*GROUP_W +: GROUP_W]),
            .term_o (grp_term[g])
        );
        assign grp_gen_o[g]  = grp_term[g].gen;
        assign grp_prop_o[g] = grp_term[g].prop;
    end

    gcla_lookahead #(.NG(N_GROUPS)) u_lookahead (
        .gg_i    (grp_gen_o),
        .gp_i    (grp_prop_o),
        .cin_i   (cin_i),
        .carry_o (grp_carry)
    );

    assign cout_o = grp_carry[N_GROUPS];
endmodule

// File: rtl/gcla_adder_chk.sv
module gcla_adder_chk #(
    parameter int unsigned GROUP_W  = gcla_pkg::GROUP_W,
    parameter int unsigned N_GROUPS = gcla_pkg::N_GROUPS,
    localparam int unsigned WIDTH   = GROUP_W * N_GROUPS
) (
    input logic [WIDTH-1:0]    a_i,
    input logic [WIDTH-1:0]    b_i,
    input logic                cin_i,
    input logic [WIDTH-1:0]    sum_o,
    input logic                cout_o,
    input logic [N_GROUPS-1:0] grp_gen_o,
    input logic [N_GROUPS-1:0] grp_prop_o
);
    logic [WIDTH:0] ref_full;
    assign ref_full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    // R1 and R2
    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i, sum_o, cout_o})) begin
            a_r1_sum_value: assert (sum_o == ref_full[WIDTH-1:0])
                else $error("R1 sum mismatch");
            a_r2_carry_out: assert (cout_o == ref_full[WIDTH])
                else $error("R2 carry-out mismatch");
        end
    end

    for (genvar g = 0; g < int'(N_GROUPS); g++) begin : g_chk
        logic [GROUP_W:0] s0;
        logic [GROUP_W:0] s1;
        assign s0 = {1'b0, a_i[g*GROUP_W +: GROUP_W]} + {1'b0, b_i[g*GROUP_W +: GROUP_W]};
        assign s1 = s0 + {{GROUP_W{1'b0}}, 1'b1};
        always_comb begin
            if (!$isunknown({a_i, b_i, grp_gen_o, grp_prop_o})) begin
                // R3: generate is the slice carry-out with carry-in 0
                a_r3_group_gen: assert (grp_gen_o[g] == s0[GROUP_W])
                    else $error("R3 group generate mismatch");
                // R5: generate or propagate is the slice carry-out with carry-in 1
                a_r5_group_pass: assert ((grp_gen_o[g] | grp_prop_o[g]) == s1[GROUP_W])
                    else $error("R5 group pass mismatch");
            end
        end
    end
endmodule

bind gcla_adder gcla_adder_chk #(.GROUP_W(GROUP_W), .N_GROUPS(N_GROUPS)) u_chk (.*);

// File: tb/gcla_adder_bench.sv
module gcla_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int NG = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a, b, sum;
    logic          cin, cout;
    logic [NG-1:0] gg, gp;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gcla_adder u_gcla_adder (
        .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout),
        .grp_gen_o(gg), .grp_prop_o(gp)
    );

    function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    function automatic logic [NG-1:0] ref_gen(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [NG-1:0] r;
        for (int k = 0; k < NG; k++) begin
            logic [4:0] s;
            s = {1'b0, x[k*4 +: 4]} + {1'b0, y[k*4 +: 4]};
            r[k] = s[4];
        end
        return r;
    endfunction

    function automatic logic [NG-1:0] ref_prop(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [NG-1:0] r;
        for (int k = 0; k < NG; k++) r[k] = &(x[k*4 +: 4] | y[k*4 +: 4]);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h (a=%h b=%h cin=%b)", req, got, exp, a, b, cin);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string tag);
        logic [W:0] e;
        @(posedge clk);
        #1;
        a = x; b = y; cin = c;
        @(negedge clk);
        e = ref_add(x, y, c);
        check({"R1 sum ", tag}, 32'(sum), 32'(e[W-1:0]));
        check({"R2 cout ", tag}, 32'(cout), 32'(e[W]));
        check({"R3 gen ", tag}, 32'(gg), 32'(ref_gen(x, y)));
        check({"R4 prop ", tag}, 32'(gp), 32'(ref_prop(x, y)));
    endtask

    initial begin
        int unsigned seed_dummy;
        a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: zero operands give zero outputs
        check("R1 reset sum", 32'(sum), 32'h0);
        check("R2 reset cout", 32'(cout), 32'h0);
        rst_n = 1'b1;

        // R6: pure propagate chain, carry-in live
        apply(16'hAAAA, 16'h5555, 1'b0, "R6 cin0");
        check("R6 prop all", 32'(gp), 32'hF);
        apply(16'hAAAA, 16'h5555, 1'b1, "R6 cin1");
        check("R6 sum wraps", 32'(sum), 32'h0);
        check("R6 cout set", 32'(cout), 32'h1);
        apply(16'h0000, 16'h0000, 1'b1, "R6 zero cin1");
        // R7: generate in low slice, propagate through all upper slices
        apply(16'hFFFF, 16'h0001, 1'b0, "R7 long carry");
        check("R7 cout", 32'(cout), 32'h1);
        check("R7 sum", 32'(sum), 32'h0);
        // R5: both gen and prop in same slices
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R5 both");
        check("R5 gen|prop", 32'(gg | gp), 32'hF);
        apply(16'h0F0F, 16'h0F0F, 1'b0, "R5 mixed");
        apply(16'h8000, 16'h8000, 1'b1, "R2 top gen");

        seed_dummy = $urandom(32'h5EED_1234);
        for (int n = 0; n < 400; n++) begin
            logic [W-1:0] x, y;
            x = W'($urandom);
            y = W'($urandom);
            // bias some vectors toward propagate-heavy slices
            if (n % 4 == 0) y = ~x ^ W'($urandom_range(0, 15));
            apply(x, y, 1'($urandom), "random R1 R3 R4 R5");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule